// File: doc/BRIEF.md
# Timer Counter Channel with Compare

A single channel of a general-purpose timer. An up-counter advances on ticks from one of five sources: the block clock divided by 2, 8, 32 or 128 (taken from a shared prescaler), or an external slow-tick strobe. The counter can run free across its full range or wrap back to zero when it matches the RC compare value. A stop-on-compare option clears the clock-active state at the RC match, so the channel counts once and then halts. Comparisons against RA and RC set and clear a waveform output pin.

Software controls the channel through a small register port. The block has a mode word, the RA and RC compare values, and a write-one command word with start, stop and restart bits. It also has a status word with sticky event flags that clear when read, and an interrupt mask with separate write-one set and write-one clear addresses. The interrupt output is high whenever a flagged event is also unmasked.

Top module: `tc_channel`

## Requirements
- R1: The source field (mode bits [2:0]) picks the tick. Codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clocks, timed from a prescaler that the restart command zeroes. Code 4 ticks on every cycle with `slow_tick` high. Codes 5 to 7 never tick.
- R2: With mode bit 3 low, each tick while the clock is active adds one to the count. At all ones the count wraps to zero and sets the wrap flag (status bit 1). RC never resets the count in this mode.
- R3: With mode bit 3 high, a tick on which the count equals RC loads zero instead of incrementing. In both modes such a tick sets the RC flag (status bit 0).
- R4: With mode bit 4 high, a tick on which the count equals RC clears the clock-active state (status bit 8). Counting stops until the clock is enabled again.
- R5: Command writes act on the next edge. Bit 0 enables the clock and bit 1 disables it; disable wins when both are set. Bit 2 zeroes the count and the prescaler and overrides any tick in that cycle.
- R6: Status (address 4) reads as flags in bits [1:0] and clock-active in bit 8. A read clears both flags. A flag raised in the same cycle as the read survives.
- R7: Ones written to address 5 set mask bits and ones written to address 6 clear them; on overlap the clear wins. Writing 0xFF to address 6 clears the whole mask. The mask reads back at address 7.
- R8: `irq` is high exactly when a set flag has its mask bit set.
- R9: `wave_out` resets low. On a tick at count equal to RA it goes high if mode bit 5 is set. On a tick at count equal to RC it goes low if mode bit 6 is set, and this clear wins over the set.
- R10: After reset, mode, RA, RC, count, flags, mask, clock-active and `wave_out` are all zero. Register map: 0 mode, 1 RA, 2 RC, 3 command, 4 status, 5 mask set, 6 mask clear, 7 mask, 8 count. Write-only addresses read as zero.
- R11: The counter, RA and RC width is the parameter `CNT_W` (16 or 32). Reads return the values zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow tick strobe, used as source code 4 |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status flags on address 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wave_out | output | 1 | Waveform pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the one-shot path. There, auto-reset and stop-on-compare land on the same tick. A design that ordered them wrongly would halt at RC instead of zero, or would keep counting after the match. It drives enable and disable in one write, where a wrong priority leaves the clock running. It also reads status just as a compare fires, where a clear-before-set ordering loses the event. A full 16-bit wrap from the slow source shows whether RC is wrongly used as a reset in free mode and whether the wrap flag is raised. The mask-clear-all write exposes a mask that ignores the clear or lets `irq` linger.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int DIV_N   = 4;              // number of prescaled sources
    localparam int PRESC_W = 2 * DIV_N - 1;  // widest divider is 2**PRESC_W
    localparam int FLAG_N  = 2;
    localparam int FLAG_RC   = 0;
    localparam int FLAG_WRAP = 1;
    localparam int STAT_ACT_BIT = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE  = 4'd0,
        A_RA    = 4'd1,
        A_RC    = 4'd2,
        A_CMD   = 4'd3,
        A_STAT  = 4'd4,
        A_ISET  = 4'd5,
        A_ICLR  = 4'd6,
        A_IMASK = 4'd7,
        A_COUNT = 4'd8
    } reg_addr_e;

    localparam logic [2:0] SRC_SLOW = 3'd4;

    // bit 6 .. bit 0
    typedef struct packed {
        logic       rc_clear;
        logic       ra_set;
        logic       stop_rc;
        logic       auto_rst;
        logic [2:0] src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic restart;
        logic dis;
        logic en;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    // Width of the prescaler slice whose all-ones state marks a tick.
    function automatic int div_span(input int code);
        return 2 * code + 1;
    endfunction

endpackage

// File: rtl/tc_clk_select.sv
`timescale 1ns/1ps
module tc_clk_select
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [2:0] src,
    input  logic       slow_tick,
    output logic       src_tick
);
    localparam int SEL_W = $clog2(DIV_N);

    logic [PRESC_W-1:0] presc;
    logic [DIV_N-1:0]   div_tick;

    always_ff @(posedge clk) begin
        if (rst || restart) presc <= '0;
        else                presc <= presc + 1'b1;
    end

    for (genvar k = 0; k < DIV_N; k++) begin : g_div
        assign div_tick[k] = &presc[div_span(k)-1:0];
    end

    always_comb begin
        if (src < 3'(DIV_N))      src_tick = div_tick[src[SEL_W-1:0]];
        else if (src == SRC_SLOW) src_tick = slow_tick;
        else                      src_tick = 1'b0;
    end
endmodule

// File: rtl/tc_count_core.sv
`timescale 1ns/1ps
module tc_count_core
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_tick,
    input  mode_t             mode,
    input  logic [CNT_W-1:0]  ra,
    input  logic [CNT_W-1:0]  rc,
    input  cmd_t              cmd,
    output logic [CNT_W-1:0]  count,
    output logic              clk_active,
    output logic              wave,
    output logic              tick,
    output logic [FLAG_N-1:0] flag_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic rc_hit, ra_hit, top_hit, reload;

    always_comb begin
        tick    = src_tick && clk_active && !cmd.restart;
        rc_hit  = tick && (count == rc);
        ra_hit  = tick && (count == ra);
        reload  = rc_hit && mode.auto_rst;
        top_hit = tick && (count == CNT_MAX) && !reload;
        flag_set            = '0;
        flag_set[FLAG_RC]   = rc_hit;
        flag_set[FLAG_WRAP] = top_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)              count <= '0;
        else if (cmd.restart) count <= '0;
        else if (reload)      count <= '0;
        else if (tick)        count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                          wave <= 1'b0;
        else if (rc_hit && mode.rc_clear) wave <= 1'b0;
        else if (ra_hit && mode.ra_set)   wave <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                         clk_active <= 1'b0;
        else if (cmd.dis)                clk_active <= 1'b0;
        else if (cmd.en)                 clk_active <= 1'b1;
        else if (rc_hit && mode.stop_rc) clk_active <= 1'b0;
    end
endmodule

// File: rtl/tc_irq_ctrl.sv
`timescale 1ns/1ps
module tc_irq_ctrl
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] flag_set,
    input  logic              rd_clear,
    input  logic              mask_set_we,
    input  logic              mask_clr_we,
    input  logic [FLAG_N-1:0] wbits,
    output logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] mask,
    output logic              irq
);
    logic [FLAG_N-1:0] set_bits, clr_bits;

    assign set_bits = mask_set_we ? wbits : '0;
    assign clr_bits = mask_clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            flags <= (flags & ~{FLAG_N{rd_clear}}) | flag_set;
            mask  <= (mask | set_bits) & ~clr_bits;
        end
    end

    assign irq = |(flags & mask);
endmodule

// File: rtl/tc_channel.sv
`timescale 1ns/1ps
module tc_channel
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wave_out,
    output logic        irq
);
    mode_t             mode_q;
    logic [CNT_W-1:0]  ra_q, rc_q, count;
    cmd_t              cmd;
    logic              src_tick, tick, clk_active;
    logic [FLAG_N-1:0] flag_set, flags, mask;
    logic              we_mode, we_ra, we_rc, we_cmd, we_iset, we_iclr, rd_stat;

    assign we_mode = bus_wr && (bus_addr == A_MODE);
    assign we_ra   = bus_wr && (bus_addr == A_RA);
    assign we_rc   = bus_wr && (bus_addr == A_RC);
    assign we_cmd  = bus_wr && (bus_addr == A_CMD);
    assign we_iset = bus_wr && (bus_addr == A_ISET);
    assign we_iclr = bus_wr && (bus_addr == A_ICLR);
    assign rd_stat = bus_rd && (bus_addr == A_STAT);

    assign cmd = we_cmd ? cmd_t'(bus_wdata[CMD_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ra_q   <= '0;
            rc_q   <= '0;
        end else begin
            if (we_mode) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            if (we_ra)   ra_q   <= bus_wdata[CNT_W-1:0];
            if (we_rc)   rc_q   <= bus_wdata[CNT_W-1:0];
        end
    end

    tc_clk_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .restart   (cmd.restart),
        .src       (mode_q.src),
        .slow_tick (slow_tick),
        .src_tick  (src_tick)
    );

    tc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .src_tick   (src_tick),
        .mode       (mode_q),
        .ra         (ra_q),
        .rc         (rc_q),
        .cmd        (cmd),
        .count      (count),
        .clk_active (clk_active),
        .wave       (wave_out),
        .tick       (tick),
        .flag_set   (flag_set)
    );

    tc_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .flag_set    (flag_set),
        .rd_clear    (rd_stat),
        .mask_set_we (we_iset),
        .mask_clr_we (we_iclr),
        .wbits       (bus_wdata[FLAG_N-1:0]),
        .flags       (flags),
        .mask        (mask),
        .irq         (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata = 32'(mode_q);
            A_RA:    bus_rdata = 32'(ra_q);
            A_RC:    bus_rdata = 32'(rc_q);
            A_STAT: begin
                bus_rdata[FLAG_N-1:0]   = flags;
                bus_rdata[STAT_ACT_BIT] = clk_active;
            end
            A_IMASK: bus_rdata = 32'(mask);
            A_COUNT: bus_rdata = 32'(count);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tc_channel_chk.sv
`timescale 1ns/1ps
module tc_channel_chk
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              tick,
    input logic              clk_active,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  rc,
    input logic              auto_rst,
    input logic              stop_rc,
    input logic [FLAG_N-1:0] mask,
    input logic              irq
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == A_CMD);

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && auto_rst && count == rc) |=> (count == '0));  // R3

    AST_STOP_ON_RC: assert property (@(posedge clk) disable iff (rst)
        (tick && stop_rc && count == rc && !(cmd_wr && bus_wdata[0])) |=> !clk_active);  // R4

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[1]) |=> !clk_active);  // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[2]) |=> (count == '0));  // R5

    AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clk_active && !cmd_wr) |=> $stable(count));  // R4

    AST_MASK_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ICLR && bus_wdata[7:0] == 8'hFF) |=> (mask == '0 && !irq));  // R7
endmodule

bind tc_channel tc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .tick       (tick),
    .clk_active (clk_active),
    .count      (count),
    .rc         (rc_q),
    .auto_rst   (mode_q.auto_rst),
    .stop_rc    (mode_q.stop_rc),
    .mask       (mask),
    .irq        (irq)
);

// File: tb/tc_channel_tb.sv
`timescale 1ns/1ps
module tc_channel_tb;
    localparam int W = 16;
    localparam logic [W-1:0] MAXV = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wave_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit live = 1'b0;
    bit slow_rand = 1'b0;

    tc_channel #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_out(wave_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Reference state built from the requirements
    logic [W-1:0] m_cnt, m_ra, m_rc;
    logic [6:0]   m_mode;
    logic [6:0]   m_presc;
    logic         m_act, m_wave;
    logic [1:0]   m_flags, m_mask;

    function automatic logic m_src_tick(input logic [6:0] mode, input logic [6:0] presc, input logic st);
        int code = int'(mode[2:0]);
        logic [6:0] sl;
        if (code < 4) begin
            sl = 7'((1 << (2 * code + 1)) - 1);
            return (presc & sl) == sl;
        end
        if (code == 4) return st;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return 32'(m_mode);
            4'd1: return 32'(m_ra);
            4'd2: return 32'(m_rc);
            4'd4: return {23'd0, m_act, 6'd0, m_flags};
            4'd7: return 32'(m_mask);
            4'd8: return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_ra = '0; m_rc = '0; m_mode = '0; m_presc = '0;
            m_act = 1'b0; m_wave = 1'b0; m_flags = '0; m_mask = '0;
        end else begin
            logic cw, rs, tk, rc_ev, ra_ev, wr_ev;
            logic [1:0] wb;
            cw = bus_wr && bus_addr == 4'd3;
            rs = cw && bus_wdata[2];
            tk = m_src_tick(m_mode, m_presc, slow_tick) && m_act && !rs;
            rc_ev = tk && (m_cnt == m_rc);
            ra_ev = tk && (m_cnt == m_ra);
            wr_ev = 1'b0;
            if (rc_ev && m_mode[6])      m_wave = 1'b0;
            else if (ra_ev && m_mode[5]) m_wave = 1'b1;
            if (cw && bus_wdata[1])      m_act = 1'b0;
            else if (cw && bus_wdata[0]) m_act = 1'b1;
            else if (rc_ev && m_mode[4]) m_act = 1'b0;
            if (rs) m_cnt = '0;
            else if (rc_ev && m_mode[3]) m_cnt = '0;
            else if (tk) begin
                if (m_cnt == MAXV) wr_ev = 1'b1;
                m_cnt = m_cnt + 1'b1;
            end
            m_presc = rs ? 7'd0 : m_presc + 7'd1;
            if (bus_rd && bus_addr == 4'd4) m_flags = 2'b00;
            m_flags = m_flags | {wr_ev, rc_ev};
            wb = bus_wdata[1:0];
            if (bus_wr && bus_addr == 4'd5) m_mask = m_mask | wb;
            if (bus_wr && bus_addr == 4'd6) m_mask = m_mask & ~wb;
            if (bus_wr && bus_addr == 4'd0) m_mode = bus_wdata[6:0];
            if (bus_wr && bus_addr == 4'd1) m_ra = bus_wdata[W-1:0];
            if (bus_wr && bus_addr == 4'd2) m_rc = bus_wdata[W-1:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Pin monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (live) begin
            check("R9 wave_out", 32'(wave_out), 32'(m_wave));
            check("R8 irq", 32'(irq), 32'(|(m_flags & m_mask)));
        end
    end

    always @(negedge clk) begin
        if (slow_rand) slow_tick = 1'($urandom_range(0, 1));
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(tag, bus_rdata, m_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R10: reset state
        rd_exp(4'd4, "R10 status", 32'h0);
        rd_exp(4'd8, "R10 count", 32'h0);
        rd_exp(4'd7, "R10 mask", 32'h0);
        rd_exp(4'd0, "R10 mode", 32'h0);
        rd_exp(4'd3, "R10 write-only reads zero", 32'h0);

        // R4 one-shot: auto, stop, RA set, div2
        wr(4'd2, 32'd5);
        wr(4'd1, 32'd2);
        wr(4'd0, 32'h38);
        wr(4'd5, 32'd1);
        wr(4'd3, 32'd5);
        idle(40);
        check("R8 irq after compare", 32'(irq), 32'd1);
        check("R9 wave set on RA", 32'(wave_out), 32'd1);
        rd_exp(4'd8, "R4 count halted at zero", 32'h0);
        rd_exp(4'd4, "R4 status halted with flag", 32'h1);
        rd_exp(4'd4, "R6 flag cleared by read", 32'h0);

        // R9 clear on RC
        wr(4'd0, 32'h58);
        wr(4'd3, 32'd5);
        idle(40);
        check("R9 wave cleared on RC", 32'(wave_out), 32'd0);
        rd(4'd4, "R6 status");

        // R5 disable wins
        wr(4'd3, 32'd3);
        rd_exp(4'd4, "R5 disable wins", 32'h0);

        // R7 mask
        wr(4'd5, 32'd3);
        rd_exp(4'd7, "R7 mask set", 32'h3);
        wr(4'd6, 32'hFF);
        rd_exp(4'd7, "R7 clear all", 32'h0);
        wr(4'd5, 32'd2);
        rd_exp(4'd7, "R7 partial set", 32'h2);

        // R1 unused source code never ticks
        wr(4'd0, 32'h5);
        wr(4'd3, 32'd1);
        idle(20);
        rd_exp(4'd8, "R1 code 5 idle", 32'h0);

        // R1 div32 free run
        wr(4'd0, 32'h2);
        wr(4'd3, 32'd5);
        idle(100);
        rd(4'd8, "R1 div32 count");
        wr(4'd0, 32'h3);
        wr(4'd3, 32'd5);
        idle(300);
        rd(4'd8, "R1 div128 count");
        wr(4'd3, 32'd2);

        // Random phase
        slow_rand = 1'b1;
        for (int i = 0; i < 1500; i++) begin
            int op = int'($urandom_range(0, 7));
            case (op)
                0: wr(4'd0, {25'd0, 4'($urandom_range(0, 15)), 3'($urandom_range(0, 5))});
                1: wr(4'd1, $urandom_range(0, 40));
                2: wr(4'd2, $urandom_range(0, 40));
                3: wr(4'd3, $urandom_range(0, 7));
                4: wr(4'd5, $urandom_range(0, 3));
                5: wr(4'd6, $urandom_range(0, 3));
                6: rd(4'($urandom_range(0, 8)), "R3 R6 R7 random readback");
                default: idle(int'($urandom_range(1, 8)));
            endcase
        end
        slow_rand = 1'b0;

        // R2 / R11: full-range wrap from the slow source
        slow_tick = 1'b1;
        wr(4'd6, 32'hFF);
        rd(4'd4, "R6 status before wrap");
        wr(4'd2, 32'h10);
        wr(4'd0, 32'h4);
        wr(4'd3, 32'd5);
        idle(65546);
        rd(4'd8, "R2 R11 count after wrap");
        rd_exp(4'd4, "R2 R11 wrap flag", 32'h103);
        slow_tick = 1'b0;

        summary();
        $finish;
    end
endmodule